// File: doc/BRIEF.md
# Register-Mapped Interrupt Aggregator

This block gathers up to 32 interrupt request lines into a single processor interrupt. A bus master reaches it through a word-indexed register bank with an address, a write strobe, write data and read data. Each input is latched into a sticky status bit. For each input, a parameter chooses whether the bit is set on a rising edge or while the line is high. An enable mask decides which latched bits count as pending. The read data port is combinational, so a read returns its value in the same cycle as the address.

Software clears latched bits by writing a mask to an acknowledge register. It can change the enable mask in three ways: replace it whole, set bits only, or clear bits only. A vector register reports the lowest-numbered pending input. A two-bit master control gates the processor interrupt. Its lower bit is an ordinary on/off switch. Its upper bit, the hardware arm, can only be set; only reset clears it.

The register index on `bus_addr` is the byte offset divided by four:

| Index | Register |
|---|---|
| 0 | status |
| 1 | pending |
| 2 | enable |
| 3 | acknowledge |
| 4 | set-enable |
| 5 | clear-enable |
| 6 | vector |
| 7 | master |

Top module: `irqc_top`

## Requirements
- R1: After reset the status, enable and master registers read zero, the vector reads all ones and `irq_o` is low.
- R2: A source whose `EDGE_SEL` bit is 0 sets its status bit on every clock edge at which its line is high. A source whose `EDGE_SEL` bit is 1 sets it only on an edge where the line is high and was low at the previous edge.
- R3: A status bit is cleared only by a write of 1 to the same bit of the acknowledge register (index 3). Bits written as 0 leave the status unchanged.
- R4: If a status bit is set and acknowledged in the same cycle, it stays set.
- R5: The status register (index 0) reads the raw latched bits. The pending register (index 1) reads status AND enable.
- R6: A write to the enable register (index 2) replaces every enable bit, with input i in bit i.
- R7: In a write to set-enable (index 4) each 1 bit sets the matching enable bit. In a write to clear-enable (index 5) each 1 bit clears it. Zero bits change nothing.
- R8: The vector register (index 6) reads the index of the lowest-numbered pending input, or all ones when nothing is pending.
- R9: In the master register (index 7), bit 0 follows each write. Bit 1 is set by a write with bit 1 at 1 and then stays 1 until reset, whatever is written later.
- R10: `irq_o` is high exactly when some pending bit is 1 and both master bits are 1.
- R11: Writes to the status, pending and vector indices change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register index (byte offset / 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_src | input | NSRC | Interrupt request lines, input i in bit i |
| irq_o | output | 1 | Processor interrupt request |

## Verification
A register write or an input pattern present at a rising edge shows up in the registers at that edge. Because the read data, the vector and `irq_o` are combinational from those registers, every result is due in the same cycle, just after the edge. The bench drives each stimulus half a period ahead of the edge and advances its own cycle model at that edge. It then reads every register a fraction of a nanosecond after the edge, finishing well before the next falling edge, so each comparison sees exactly one clock of effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  // Register indices; the index is the byte offset divided by four.
  typedef enum logic [IDX_W-1:0] {
    RIX_STAT  = 3'd0,
    RIX_PEND  = 3'd1,
    RIX_ENAB  = 3'd2,
    RIX_ACK   = 3'd3,
    RIX_SETEN = 3'd4,
    RIX_CLREN = 3'd5,
    RIX_VEC   = 3'd6,
    RIX_MSTR  = 3'd7
  } irqc_reg_e;

  // Master control: bit 0 follows the write, bit 1 can only be raised.
  function automatic logic [1:0] master_next(input logic [1:0] cur,
                                             input logic [1:0] wr);
    master_next = {cur[1] | wr[1], wr[0]};
  endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int unsigned     NSRC     = 32,
  parameter logic [NSRC-1:0] EDGE_SEL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] ack_i,
  output logic [NSRC-1:0] set_o,
  output logic [NSRC-1:0] status_o
);

  logic [NSRC-1:0] status_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (EDGE_SEL[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i[g];
      end
      assign set_o[g] = src_i[g] & ~prev_q;
    end else begin : g_level
      assign set_o[g] = src_i[g];
    end
  end

  // A new set has priority over an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~ack_i) | set_o;
  end

  assign status_o = status_q;

endmodule

// File: rtl/irqc_enable.sv
module irqc_enable #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_all_i,
  input  logic            wr_set_i,
  input  logic            wr_clr_i,
  input  logic [NSRC-1:0] data_i,
  output logic [NSRC-1:0] en_o
);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_all_i)      en_d = data_i;
    else if (wr_set_i) en_d = en_q | data_i;
    else if (wr_clr_i) en_d = en_q & ~data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

endmodule

// File: rtl/irqc_vector.sv
module irqc_vector #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic [NSRC-1:0]   pend_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              any_o
);

  // Scan from the top down, so the lowest set index is the one that remains.
  always_comb begin
    vec_o = '1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = DATA_W'(i);
    end
  end

  assign any_o = |pend_i;

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned     NSRC     = 32,
  parameter logic [NSRC-1:0] EDGE_SEL = 32'hFFFF_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [irqc_pkg::IDX_W-1:0]  bus_addr,
  input  logic                        bus_we,
  input  logic [irqc_pkg::DATA_W-1:0] bus_wdata,
  output logic [irqc_pkg::DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]             irq_src,
  output logic                        irq_o
);
  import irqc_pkg::*;

  irqc_reg_e       sel;
  logic            wr_ack;
  logic            wr_all;
  logic            wr_set;
  logic            wr_clr;
  logic            wr_mstr;
  logic [NSRC-1:0] ack_mask;
  logic [NSRC-1:0] cap_set;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] enable;
  logic [NSRC-1:0] pend;
  logic [DATA_W-1:0] vec;
  logic            any_pend;
  logic [1:0]      master_q;

  assign sel     = irqc_reg_e'(bus_addr);
  assign wr_ack  = bus_we && (sel == RIX_ACK);
  assign wr_all  = bus_we && (sel == RIX_ENAB);
  assign wr_set  = bus_we && (sel == RIX_SETEN);
  assign wr_clr  = bus_we && (sel == RIX_CLREN);
  assign wr_mstr = bus_we && (sel == RIX_MSTR);
  assign ack_mask = wr_ack ? bus_wdata[NSRC-1:0] : '0;

  irqc_capture #(.NSRC(NSRC), .EDGE_SEL(EDGE_SEL)) cap_i (
    .clk(clk), .rst_n(rst_n), .src_i(irq_src), .ack_i(ack_mask),
    .set_o(cap_set), .status_o(status)
  );

  irqc_enable #(.NSRC(NSRC)) en_i (
    .clk(clk), .rst_n(rst_n), .wr_all_i(wr_all), .wr_set_i(wr_set),
    .wr_clr_i(wr_clr), .data_i(bus_wdata[NSRC-1:0]), .en_o(enable)
  );

  assign pend = status & enable;

  irqc_vector #(.NSRC(NSRC), .DATA_W(DATA_W)) vec_i (
    .pend_i(pend), .vec_o(vec), .any_o(any_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       master_q <= 2'b00;
    else if (wr_mstr) master_q <= master_next(master_q, bus_wdata[1:0]);
  end

  assign irq_o = any_pend & master_q[0] & master_q[1];

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RIX_STAT: bus_rdata[NSRC-1:0] = status;
      RIX_PEND: bus_rdata[NSRC-1:0] = pend;
      RIX_ENAB: bus_rdata[NSRC-1:0] = enable;
      RIX_VEC:  bus_rdata           = vec;
      RIX_MSTR: bus_rdata[1:0]      = master_q;
      default:  bus_rdata           = '0;
    endcase
  end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] cap_set,
  input logic [NSRC-1:0] ack_mask,
  input logic [NSRC-1:0] pend,
  input logic [31:0]     vec,
  input logic [1:0]      master_q,
  input logic            irq_o
);

  // R3
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~status) & ~$past(ack_mask)) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cap_set) & ~status) == '0));

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (vec == 32'hFFFF_FFFF));

  // R8
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> (vec < NSRC));

  // R9
  hw_arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_q[1] |=> master_q[1]);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (master_q == 2'b11 && pend != '0));

endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .status(status), .cap_set(cap_set),
  .ack_mask(ack_mask), .pend(pend), .vec(vec), .master_q(master_q),
  .irq_o(irq_o)
);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/100ps
module irqc_top_tb_top;
  localparam int unsigned N = 8;
  localparam logic [N-1:0] EDGES = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_src = '0;
  logic irq_o;

  int total = 0;
  int fails = 0;

  logic [N-1:0] m_stat = '0;
  logic [N-1:0] m_en = '0;
  logic [1:0]   m_mst = '0;
  logic [N-1:0] m_prev = '0;

  always #2 clk = ~clk;

  irqc_top #(.NSRC(N), .EDGE_SEL(EDGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  // One clock: stimulus before the edge, model update at the edge.
  task automatic cyc(input logic [N-1:0] src, input logic we,
                     input logic [2:0] a, input logic [31:0] d);
    logic [N-1:0] ack;
    @(negedge clk);
    irq_src = src; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    ack = (we && a == 3'd3) ? d[N-1:0] : '0;
    for (int b = 0; b < N; b++) begin
      logic s;
      s = EDGES[b] ? (src[b] && !m_prev[b]) : src[b];
      if (s) m_stat[b] = 1'b1;
      else if (ack[b]) m_stat[b] = 1'b0;
    end
    m_prev = src;
    if (we) begin
      case (a)
        3'd2: m_en = d[N-1:0];
        3'd4: for (int b = 0; b < N; b++) if (d[b]) m_en[b] = 1'b1;
        3'd5: for (int b = 0; b < N; b++) if (d[b]) m_en[b] = 1'b0;
        3'd7: begin m_mst[0] = d[0]; if (d[1]) m_mst[1] = 1'b1; end
        default: ;
      endcase
    end
    #0.3;
    bus_we = 1'b0;
  endtask

  task automatic compare_all(input string ctx);
    logic [31:0] v;
    logic [31:0] ev;
    logic [N-1:0] p;
    p = m_stat & m_en;
    ev = 32'hFFFF_FFFF;
    for (int b = 0; b < N; b++) if (p[b] && ev == 32'hFFFF_FFFF) ev = b;
    rd(3'd0, v); chk({ctx, " R3 status"}, v, {24'h0, m_stat});
    rd(3'd1, v); chk({ctx, " R5 pending"}, v, {24'h0, p});
    rd(3'd2, v); chk({ctx, " R6 enable"}, v, {24'h0, m_en});
    rd(3'd6, v); chk({ctx, " R8 vector"}, v, ev);
    rd(3'd7, v); chk({ctx, " R9 master"}, v, {30'h0, m_mst});
    chk({ctx, " R10 irq"}, {31'h0, irq_o}, {31'h0, (p != 0) && m_mst == 2'b11});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #0.5;
    compare_all("R1 reset");

    // R11 writes to read-only indices
    cyc('0, 1'b1, 3'd2, 32'h0000_00FF);
    cyc('0, 1'b1, 3'd0, 32'hFFFF_FFFF);
    cyc('0, 1'b1, 3'd1, 32'hFFFF_FFFF);
    cyc('0, 1'b1, 3'd6, 32'hFFFF_FFFF);
    compare_all("R11");

    // R6 replace and complement-disable
    cyc('0, 1'b1, 3'd2, 32'h0000_00A5); compare_all("R6 write");
    cyc('0, 1'b1, 3'd2, ~32'h0000_0005); compare_all("R6 disable");
    // R7 alias writes
    cyc('0, 1'b1, 3'd4, 32'h0000_000F); compare_all("R7 set");
    cyc('0, 1'b1, 3'd5, 32'h0000_0081); compare_all("R7 clear");

    // R9 hardware arm survives a zero write
    cyc('0, 1'b1, 3'd7, 32'h3); compare_all("R9 arm");
    cyc('0, 1'b1, 3'd7, 32'h0);
    rd(3'd7, v); chk("R9 bit1 after zero write", v, 32'h2);
    cyc('0, 1'b1, 3'd7, 32'h3);
    cyc('0, 1'b1, 3'd2, 32'hFF);

    // R2 per-source sweep, held high across an acknowledge
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] one;
      one = N'(1) << i;
      cyc(one, 1'b0, 3'd0, 0); compare_all("R2 raise");
      cyc(one, 1'b1, 3'd3, {24'h0, one}); compare_all("R4 ack while high");
      cyc(one, 1'b1, 3'd3, {24'h0, one}); compare_all("R2 held ack");
      cyc('0, 1'b1, 3'd3, {24'h0, one}); compare_all("R3 ack");
    end

    // R4 explicit: level source 0 high while acknowledged
    cyc(8'h01, 1'b1, 3'd3, 32'h1);
    rd(3'd0, v); chk("R4 set beats ack", v[0], 32'h1);
    cyc('0, 1'b1, 3'd3, 32'h1);
    rd(3'd0, v); chk("R3 cleared", v, 32'h0);

    // Mixed patterns
    lf = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      logic [2:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf[10:8];
      cyc(lf[7:0], lf[12], a, {lf[31:16], lf[23:8]});
      if (k % 4 == 0) compare_all("mix");
    end
    cyc('0, 1'b1, 3'd7, 32'h0);
    rd(3'd7, v); chk("R9 final bit1", v[1], 32'h1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule